// File: doc/BRIEF.md
# Scratchpad Slot with FIFO Fill-Level Window

This block is one 8-bit location in the register file of a serial port. Normally it is a general-purpose scratch byte that the host can write and read back. A separate swap control turns the location into a read window onto the fill counts of the receive and transmit queues. Writes at the same location then stop reaching the scratch byte and load a write-only mode byte instead. The two low bits of the mode byte choose what a read returns: the scratch byte, the receive count, the transmit count, or the two counts in turn.

The host-side decoder delivers strobes that are already qualified by address, so one `rd_stb` or `wr_stb` pulse is one access to this slot. Each read is answered one cycle later on `rd_data`, flagged by a single-cycle `rd_valid`. There is no back-pressure: a read strobe is always accepted, and its answer stays on `rd_data` until the next read. The upper six bits of the mode byte are stored as written and appear on `mode_sel` for the neighbouring logic that decodes them.

Top module: `scratch_lvl_slot`

## Requirements
- R1: After reset the scratch byte is 0xFF, `mode_sel` is 0x00, `rd_data` is 0x00 and `rd_valid` is 0.
- R2: With `swap_en` = 0, a write stores `wr_data` in the scratch byte and a read returns the scratch byte, whatever the mode byte holds.
- R3: With `swap_en` = 1, a write loads `wr_data` into the mode byte (shown on `mode_sel`) and leaves the scratch byte unchanged.
- R4: With `swap_en` = 1, `mode_sel[1:0]` selects the read source: 00 the scratch byte, 01 `rx_level`, 10 `tx_level`, 11 the alternating sequence. Levels run from 0 to 128 and are returned zero-extended to 8 bits.
- R5: In mode 11, the first read after any mode-byte write returns `rx_level`, and the reads that follow return `tx_level`, `rx_level`, `tx_level` and so on.
- R6: The alternation moves forward only on a read strobe made while `swap_en` = 1 and the mode is 11. Idle cycles, changes in level, and reads made with `swap_en` = 0 leave it where it is.
- R7: While `sleep` = 1, writes that would reach the scratch byte are ignored and its value is kept. Reads still work.
- R8: `rd_valid` is high in exactly the cycle after each read strobe. `rd_data` then holds the source value sampled at the strobe edge, and it does not change until the next read.
- R9: When a read and a write arrive in the same cycle, the read returns the state from before the write. The write takes effect for later reads, and a mode-byte write restarts the alternation even if the same read strobe would have moved it forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep | input | 1 | Low-power indication; freezes the scratch byte |
| swap_en | input | 1 | 1 = location acts as mode byte / level window |
| wr_stb | input | 1 | Address-qualified write strobe |
| rd_stb | input | 1 | Address-qualified read strobe |
| wr_data | input | 8 | Write data |
| rx_level | input | 8 | Live receive-queue fill count (0..128) |
| tx_level | input | 8 | Live transmit-queue fill count (0..128) |
| rd_data | output | 8 | Read answer, held until the next read |
| rd_valid | output | 1 | One-cycle flag that `rd_data` holds a new answer |
| mode_sel | output | 8 | Current contents of the mode byte |

## Verification
A wrong alternation phase shows up on the next mode-11 read, one cycle after its strobe, as the receive count where the transmit count was due or the other way round. Because of this, the bench gives the two counts different values on every read. A corrupted scratch byte stays hidden until the host reads with the window switched off, so every write in the sweeps is followed at once by a read-back. A mode byte that is lost or wrongly latched shows on `mode_sel` in the cycle after the write, and on the read source at the next read.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic [1:0] {
    LV_SCRATCH = 2'b00,
    LV_RX      = 2'b01,
    LV_TX      = 2'b10,
    LV_ALT     = 2'b11
  } lvl_mode_e;
endpackage

// File: rtl/scr_store.sv
// Scratch byte: preset value at reset, frozen while sleeping.
module scr_store #(
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  RST_VAL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sleep,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q_r <= DATA_W'(RST_VAL);
    else if (we && !sleep)
      q_r <= d;
  end

  assign q = q_r;
endmodule

// File: rtl/scr_mode_reg.sv
// Write-only mode byte; all bits stored, low two decoded locally.
module scr_mode_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q_r <= '0;
    else if (we)
      q_r <= d;
  end

  assign q = q_r;
endmodule

// File: rtl/scr_rd_path.sv
// Read source selection, alternation phase and registered answer.
module scr_rd_path
  import scr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic              swap_en,
  input  lvl_mode_e         mode,
  input  logic              clr_phase,
  input  logic [DATA_W-1:0] scr,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  tx_level,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              phase
);
  logic [DATA_W-1:0] rx_ext, tx_ext, src;
  logic [DATA_W-1:0] rd_q;
  logic              vld_q, phase_q;
  logic              step;

  // zero-extend level counts to the bus width
  generate
    if (LVL_W == DATA_W) begin : g_same
      assign rx_ext = rx_level;
      assign tx_ext = tx_level;
    end else begin : g_pad
      assign rx_ext = {{(DATA_W-LVL_W){1'b0}}, rx_level};
      assign tx_ext = {{(DATA_W-LVL_W){1'b0}}, tx_level};
    end
  endgenerate

  always_comb begin
    src = scr;
    if (swap_en) begin
      unique case (mode)
        LV_SCRATCH: src = scr;
        LV_RX:      src = rx_ext;
        LV_TX:      src = tx_ext;
        LV_ALT:     src = phase_q ? tx_ext : rx_ext;
        default:    src = scr;
      endcase
    end
  end

  assign step = rd_stb && swap_en && (mode == LV_ALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else if (clr_phase) begin
      phase_q <= 1'b0;
    end else if (step) begin
      phase_q <= ~phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= rd_stb;
      if (rd_stb)
        rd_q <= src;
    end
  end

  assign rd_data  = rd_q;
  assign rd_valid = vld_q;
  assign phase    = phase_q;
endmodule

// File: rtl/scratch_lvl_slot.sv
module scratch_lvl_slot
  import scr_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter int         FIFO_DEPTH = 128,
  parameter logic [7:0] SCR_RST    = 8'hFF,
  localparam int        LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              swap_en,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  tx_level,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] mode_sel
);
  logic [DATA_W-1:0] scr_q;
  logic [DATA_W-1:0] mode_q;
  logic              alt_phase;
  logic              scr_we, mode_we;
  lvl_mode_e         lv_mode;

  assign scr_we  = wr_stb && !swap_en;
  assign mode_we = wr_stb &&  swap_en;
  assign lv_mode = lvl_mode_e'(mode_q[1:0]);

  scr_store #(.DATA_W(DATA_W), .RST_VAL(SCR_RST)) u_store (
    .clk(clk), .rst_n(rst_n), .we(scr_we), .sleep(sleep),
    .d(wr_data), .q(scr_q)
  );

  scr_mode_reg #(.DATA_W(DATA_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .we(mode_we), .d(wr_data), .q(mode_q)
  );

  scr_rd_path #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .swap_en(swap_en),
    .mode(lv_mode), .clr_phase(mode_we), .scr(scr_q),
    .rx_level(rx_level), .tx_level(tx_level),
    .rd_data(rd_data), .rd_valid(rd_valid), .phase(alt_phase)
  );

  assign mode_sel = mode_q;
endmodule

// File: rtl/scratch_lvl_slot_chk.sv
module scratch_lvl_slot_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              swap_en,
  input logic              wr_stb,
  input logic              rd_stb,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic [DATA_W-1:0] mode_sel,
  input logic [DATA_W-1:0] scr_q,
  input logic              alt_phase
);
  // R8
  rd_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);
  // R8
  rd_valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid);
  // R8
  rd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && swap_en) |=> $stable(mode_sel));
  // R3
  scr_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && swap_en) |=> $stable(scr_q));
  // R7
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(scr_q));
  // R5
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && swap_en) |=> !alt_phase);
  // R6
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && swap_en && mode_sel[1:0] == 2'b11 && !wr_stb)
      |=> (alt_phase != $past(alt_phase)));
  // R6
  phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !wr_stb) |=> $stable(alt_phase));
endmodule

bind scratch_lvl_slot scratch_lvl_slot_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .swap_en(swap_en),
  .wr_stb(wr_stb), .rd_stb(rd_stb), .rd_data(rd_data),
  .rd_valid(rd_valid), .mode_sel(mode_sel), .scr_q(scr_q),
  .alt_phase(alt_phase)
);

// File: tb/tb_scratch_lvl_slot.sv
module tb_scratch_lvl_slot;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep = 1'b0, swap_en = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] wr_data = '0, rx_level = '0, tx_level = '0;
  logic [7:0] rd_data, mode_sel;
  logic       rd_valid;

  int n_vec = 0, n_bad = 0, cyc = 0;
  logic [7:0] m_sc, m_mode, last_rd;
  logic       m_ph;

  always #10 clk = ~clk;   // 50 MHz

  scratch_lvl_slot dut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .swap_en(swap_en),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .wr_data(wr_data),
    .rx_level(rx_level), .tx_level(tx_level),
    .rd_data(rd_data), .rd_valid(rd_valid), .mode_sel(mode_sel)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%02h exp=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd();
    if (!swap_en) return m_sc;
    case (m_mode[1:0])
      2'b00:   return m_sc;
      2'b01:   return rx_level;
      2'b10:   return tx_level;
      default: return m_ph ? tx_level : rx_level;
    endcase
  endfunction

  // one bus cycle: drive at negedge, look at results at the following negedge
  task automatic access(input logic wr, input logic rd, input logic [7:0] d, input string req);
    logic [7:0] exp;
    exp = model_rd();
    @(negedge clk);
    wr_stb = wr; rd_stb = rd; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
    if (rd) begin
      m_ph = (swap_en && m_mode[1:0] == 2'b11) ? ~m_ph : m_ph;
      last_rd = exp;
    end
    if (wr) begin
      if (swap_en) begin m_mode = d; m_ph = 1'b0; end
      else if (!sleep) m_sc = d;
    end
    chk({req, " rd_valid"}, {7'd0, rd_valid}, {7'd0, rd});
    if (rd) chk(req, rd_data, exp);
    else    chk({req, " hold"}, rd_data, last_rd);
    if (wr && swap_en) chk({req, " mode_sel"}, mode_sel, d);
  endtask

  task automatic set_mode(input logic [1:0] m);
    swap_en = 1'b1;
    access(1'b1, 1'b0, {6'd0, m}, "R3");
  endtask

  initial begin
    m_sc = 8'hFF; m_mode = 8'h00; m_ph = 1'b0; last_rd = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset values at the ports
    chk("R1 rd_valid", {7'd0, rd_valid}, 8'd0);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 mode_sel", mode_sel, 8'h00);
    rst_n = 1'b1;
    access(1'b0, 1'b1, 8'h00, "R1 scratch preset");

    // R2: full sweep of the scratch byte
    for (int v = 0; v < 256; v++) begin
      access(1'b1, 1'b0, 8'(v), "R2 write");
      access(1'b0, 1'b1, 8'h00, "R2 readback");
    end
    // R2: mode bits ignored when the window is off
    set_mode(2'b01);
    swap_en = 1'b0; rx_level = 8'd77;
    access(1'b1, 1'b0, 8'h5A, "R2 write m01");
    access(1'b0, 1'b1, 8'h00, "R2 read m01");

    // R3: a window-on write lands in the mode byte, scratch unchanged
    swap_en = 1'b1;
    access(1'b1, 1'b0, 8'hA4, "R3 mode write");
    swap_en = 1'b0;
    access(1'b0, 1'b1, 8'h00, "R3 scratch kept");

    // R4: level windows across the full count range
    set_mode(2'b01);
    for (int l = 0; l <= 128; l++) begin
      rx_level = 8'(l); tx_level = 8'(128 - l);
      access(1'b0, 1'b1, 8'h00, "R4 rx level");
    end
    set_mode(2'b10);
    for (int l = 0; l <= 128; l++) begin
      rx_level = 8'(l); tx_level = 8'(128 - l);
      access(1'b0, 1'b1, 8'h00, "R4 tx level");
    end
    set_mode(2'b00);
    access(1'b0, 1'b1, 8'h00, "R4 scratch mode");

    // R8: answer held while levels move and no read comes
    set_mode(2'b01);
    rx_level = 8'd9;
    access(1'b0, 1'b1, 8'h00, "R8 read");
    for (int k = 0; k < 4; k++) begin
      rx_level = 8'(20 + k);
      access(1'b0, 1'b0, 8'h00, "R8 idle");
    end

    // R5/R6: alternation with idle gaps and off-window reads between
    set_mode(2'b11);
    for (int k = 0; k < 24; k++) begin
      rx_level = 8'(k);
      tx_level = 8'(100 + k);
      access(1'b0, 1'b1, 8'h00, "R5 alt read");
      if (k % 3 == 1) access(1'b0, 1'b0, 8'h00, "R6 idle");
      if (k % 5 == 2) begin
        swap_en = 1'b0;
        access(1'b0, 1'b1, 8'h00, "R6 off-window read");
        swap_en = 1'b1;
      end
      if (k % 7 == 4) access(1'b1, 1'b0, 8'h03, "R5 restart");
    end

    // R9: read and mode write in the same cycle, restart wins
    access(1'b0, 1'b1, 8'h00, "R9 pre");
    rx_level = 8'd1; tx_level = 8'd2;
    access(1'b1, 1'b1, 8'h03, "R9 rd+mode wr");
    access(1'b0, 1'b1, 8'h00, "R9 rx after restart");
    // R9: scratch read and write together return the old byte
    swap_en = 1'b0;
    access(1'b1, 1'b0, 8'h11, "R9 setup");
    access(1'b1, 1'b1, 8'h22, "R9 rd+wr scratch");
    access(1'b0, 1'b1, 8'h00, "R9 new value");

    // R7: writes ignored while sleeping, reads still answered
    sleep = 1'b1;
    access(1'b1, 1'b0, 8'h3C, "R7 sleep write");
    access(1'b0, 1'b1, 8'h00, "R7 sleep read");
    sleep = 1'b0;
    access(1'b1, 1'b0, 8'hC3, "R7 wake write");
    access(1'b0, 1'b1, 8'h00, "R7 wake read");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule